// File: doc/BRIEF.md
# DMA Page Register Address Extender

This block holds the page bytes that lift a 16-bit DMA channel address to a full 32-bit physical address. It has two banks of eight 8-bit registers. The low bank supplies address bits [23:16]. The high bank supplies bits [31:24]. Software reaches the low bank with byte or word writes and the high bank with byte writes only. Both banks can be read back.

For a channel index it picks the page register pair that belongs to that channel. It then combines that pair with the channel's current address to give the physical address. The mapping from channel to register is fixed and not sequential. Registers with no channel behind them serve as plain scratch storage.

A parameter selects the 8-bit controller variant or the 16-bit one. In the 16-bit variant the current address is a word address, so it is shifted left by one, and bit 0 of the low page byte is ignored.

Top module: `dma_page_extender`

## Requirements
- R1: The channel index selects page register offset 7 for channel 0, offset 3 for channel 1, offset 1 for channel 2 and offset 2 for channel 3. The same offset is used in both banks.
- R2: A byte write to the low bank (wr_hi=0, wr_word=0) at offset r loads wr_data[7:0] into low register r and clears high register r. No other register changes.
- R3: A word write to the low bank (wr_hi=0, wr_word=1) at offset r makes three changes:
  - low register r takes wr_data[7:0];
  - low register (r+1) mod 8 takes wr_data[15:8];
  - high registers r and (r+1) mod 8 are both cleared.
- R4: A byte write to the high bank (wr_hi=1, wr_word=0) at offset r loads wr_data[7:0] into high register r and leaves the low bank unchanged.
- R5: A word-sized access to the high bank is ignored. A write changes no register, and a read returns 0.
- R6: Reads are combinational from rd_ofs, rd_hi and rd_word:
  - low byte read returns {8'h00, low[r]};
  - low word read returns {low[(r+1) mod 8], low[r]};
  - high byte read returns {8'h00, high[r]}.
- R7: In the 8-bit variant (WORD_CTRL=0), phys_addr = high<<24 | low<<16 | cur_addr, using the page pair selected by R1.
- R8: In the 16-bit variant (WORD_CTRL=1), phys_addr = high<<24 | (low with bit 0 forced to 0)<<16 | (cur_addr<<1). Bit 15 of cur_addr therefore lands on bit 16.
- R9: A synchronous active-low reset clears all sixteen registers. A write takes effect at the clock edge where wr_en is sampled high, and is not visible on the read port before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wr_hi | input | 1 | 1 selects the high bank, 0 the low bank |
| wr_word | input | 1 | 1 for a word write, 0 for a byte write |
| wr_ofs | input | 3 | Register offset of the write |
| wr_data | input | 16 | Write data; the low byte goes to offset r |
| rd_hi | input | 1 | 1 selects the high bank for the read |
| rd_word | input | 1 | 1 for a word read, 0 for a byte read |
| rd_ofs | input | 3 | Register offset of the read |
| rd_data | output | 16 | Read data |
| ch_idx | input | 2 | Channel whose address is formed |
| cur_addr | input | 16 | Current address of that channel |
| phys_addr | output | 32 | Formed physical address |

## Verification
A wrong register value appears on rd_data in the same cycle that offset is read, and on phys_addr as soon as the channel that maps to it is selected. No pipeline hides it. The sharpest symptoms are the following:
- A missed high-page clear on a low write shows as a stale top byte on the next high read.
- A missed wrap on a word write at offset 7 leaves offset 0 unchanged.
- A wrong channel map moves phys_addr[31:16] to another pair's contents.

Both variants are driven with the same stimulus, so the bit-0 masking and the shift of the 16-bit variant show up as differences in bits [16:0] only.

// File: rtl/dpx_pkg.sv
// Shared definitions for the page register address extender.
// Assumes four channels per controller and an eight-entry page bank.
package dpx_pkg;
    localparam int CHANNELS = 4;

    // Fixed channel-to-page-register map (R1).
    function automatic logic [2:0] chan_page_ofs(input logic [1:0] ch);
        logic [2:0] ofs;
        case (ch)
            2'd0:    ofs = 3'd7;
            2'd1:    ofs = 3'd3;
            2'd2:    ofs = 3'd1;
            default: ofs = 3'd2;
        endcase
        return ofs;
    endfunction
endpackage

// File: rtl/dpx_bank.sv
// Bank of N_PAGE registers of PAGE_W bits each.
// Every entry has its own load and clear strobe; load wins over clear.
// Assumes synchronous active-low reset clears every entry.
module dpx_bank #(
    parameter int N_PAGE = 8,
    parameter int PAGE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_PAGE-1:0]             ld,
    input  logic [N_PAGE-1:0]             clr,
    input  logic [N_PAGE-1:0][PAGE_W-1:0] ld_val,
    output logic [N_PAGE-1:0][PAGE_W-1:0] q
);
    for (genvar i = 0; i < N_PAGE; i++) begin : g_ent
        // Hold, load or clear one entry.
        always_ff @(posedge clk) begin
            if (!rst_n)      q[i] <= '0;
            else if (ld[i])  q[i] <= ld_val[i];
            else if (clr[i]) q[i] <= '0;
        end
    end
endmodule

// File: rtl/dpx_wr_decode.sv
// Turns one write request into per-register load and clear strobes for
// both banks. Word writes to the low bank touch offsets r and r+1 mod
// N_PAGE. Word writes to the high bank produce no strobe.
// Assumes N_PAGE is a power of two so the offset arithmetic wraps.
module dpx_wr_decode #(
    parameter int N_PAGE = 8,
    parameter int PAGE_W = 8,
    localparam int OFS_W = $clog2(N_PAGE)
) (
    input  logic                          wr_en,
    input  logic                          wr_hi,
    input  logic                          wr_word,
    input  logic [OFS_W-1:0]              wr_ofs,
    input  logic [2*PAGE_W-1:0]           wr_data,
    output logic [N_PAGE-1:0]             lo_ld,
    output logic [N_PAGE-1:0][PAGE_W-1:0] lo_val,
    output logic [N_PAGE-1:0]             hi_ld,
    output logic [N_PAGE-1:0]             hi_clr,
    output logic [N_PAGE-1:0][PAGE_W-1:0] hi_val
);
    logic [OFS_W-1:0] ofs_nxt;
    assign ofs_nxt = wr_ofs + OFS_W'(1);

    // Build the strobes and per-entry data for the addressed registers.
    always_comb begin
        lo_ld  = '0;
        hi_ld  = '0;
        hi_clr = '0;
        lo_val = '0;
        hi_val = '0;
        if (wr_en && !wr_hi) begin
            lo_ld[wr_ofs]  = 1'b1;
            hi_clr[wr_ofs] = 1'b1;
            lo_val[wr_ofs] = wr_data[PAGE_W-1:0];
            if (wr_word) begin
                lo_ld[ofs_nxt]  = 1'b1;
                hi_clr[ofs_nxt] = 1'b1;
                lo_val[ofs_nxt] = wr_data[2*PAGE_W-1:PAGE_W];
            end
        end
        if (wr_en && wr_hi && !wr_word) begin
            hi_ld[wr_ofs]  = 1'b1;
            hi_val[wr_ofs] = wr_data[PAGE_W-1:0];
        end
    end
endmodule

// File: rtl/dpx_rd_mux.sv
// Combinational read port over both banks.
// The high bank answers byte reads only; a word read of it returns zero.
module dpx_rd_mux #(
    parameter int N_PAGE = 8,
    parameter int PAGE_W = 8,
    localparam int OFS_W = $clog2(N_PAGE)
) (
    input  logic [N_PAGE-1:0][PAGE_W-1:0] lo_q,
    input  logic [N_PAGE-1:0][PAGE_W-1:0] hi_q,
    input  logic                          rd_hi,
    input  logic                          rd_word,
    input  logic [OFS_W-1:0]              rd_ofs,
    output logic [2*PAGE_W-1:0]           rd_data
);
    logic [OFS_W-1:0] ofs_nxt;
    assign ofs_nxt = rd_ofs + OFS_W'(1);

    // Select the bank, offset and width of the returned data.
    always_comb begin
        case ({rd_hi, rd_word})
            2'b00:   rd_data = {{PAGE_W{1'b0}}, lo_q[rd_ofs]};
            2'b01:   rd_data = {lo_q[ofs_nxt], lo_q[rd_ofs]};
            2'b10:   rd_data = {{PAGE_W{1'b0}}, hi_q[rd_ofs]};
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dpx_addr_form.sv
// Forms the physical address for one channel from its page pair and its
// current address. WORD_CTRL=1 selects the 16-bit controller variant:
// the page bit 0 is masked and the current address is shifted left by one.
module dpx_addr_form #(
    parameter int N_PAGE    = 8,
    parameter int PAGE_W    = 8,
    parameter int CUR_W     = 16,
    parameter bit WORD_CTRL = 1'b0,
    localparam int PHYS_W   = 2*PAGE_W + CUR_W
) (
    input  logic [N_PAGE-1:0][PAGE_W-1:0] lo_q,
    input  logic [N_PAGE-1:0][PAGE_W-1:0] hi_q,
    input  logic [1:0]                    ch_idx,
    input  logic [CUR_W-1:0]              cur_addr,
    output logic [PHYS_W-1:0]             phys_addr
);
    import dpx_pkg::*;

    logic [2:0]        sel;
    logic [PAGE_W-1:0] lo_pg;
    logic [PHYS_W-1:0] cur_ext;

    assign sel     = chan_page_ofs(ch_idx);
    assign cur_ext = PHYS_W'(cur_addr);

    if (WORD_CTRL) begin : g_word
        // Word controller: mask page bit 0, shift word address left by one.
        always_comb begin
            lo_pg     = {lo_q[sel][PAGE_W-1:1], 1'b0};
            phys_addr = {hi_q[sel], lo_pg, {CUR_W{1'b0}}} | (cur_ext << 1);
        end
    end else begin : g_byte
        // Byte controller: pages and address are used as they stand.
        always_comb begin
            lo_pg     = lo_q[sel];
            phys_addr = {hi_q[sel], lo_pg, {CUR_W{1'b0}}} | cur_ext;
        end
    end
endmodule

// File: rtl/dma_page_extender.sv
// Page register address extender for one DMA controller.
// Holds a low and a high page bank, decodes writes, serves reads and
// forms the physical address of the selected channel.
// Assumes eight page registers, as the channel map requires.
module dma_page_extender #(
    parameter int N_PAGE    = 8,
    parameter int PAGE_W    = 8,
    parameter int CUR_W     = 16,
    parameter bit WORD_CTRL = 1'b0,
    localparam int OFS_W    = $clog2(N_PAGE),
    localparam int PHYS_W   = 2*PAGE_W + CUR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_hi,
    input  logic                wr_word,
    input  logic [OFS_W-1:0]    wr_ofs,
    input  logic [2*PAGE_W-1:0] wr_data,
    input  logic                rd_hi,
    input  logic                rd_word,
    input  logic [OFS_W-1:0]    rd_ofs,
    output logic [2*PAGE_W-1:0] rd_data,
    input  logic [1:0]          ch_idx,
    input  logic [CUR_W-1:0]    cur_addr,
    output logic [PHYS_W-1:0]   phys_addr
);
    logic [N_PAGE-1:0]             lo_ld, hi_ld, hi_clr;
    logic [N_PAGE-1:0][PAGE_W-1:0] lo_val, hi_val;
    logic [N_PAGE-1:0][PAGE_W-1:0] lo_q, hi_q;

    dpx_wr_decode #(.N_PAGE(N_PAGE), .PAGE_W(PAGE_W)) u_dec (
        .wr_en   (wr_en),
        .wr_hi   (wr_hi),
        .wr_word (wr_word),
        .wr_ofs  (wr_ofs),
        .wr_data (wr_data),
        .lo_ld   (lo_ld),
        .lo_val  (lo_val),
        .hi_ld   (hi_ld),
        .hi_clr  (hi_clr),
        .hi_val  (hi_val)
    );

    dpx_bank #(.N_PAGE(N_PAGE), .PAGE_W(PAGE_W)) u_lo (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (lo_ld),
        .clr    ('0),
        .ld_val (lo_val),
        .q      (lo_q)
    );

    dpx_bank #(.N_PAGE(N_PAGE), .PAGE_W(PAGE_W)) u_hi (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (hi_ld),
        .clr    (hi_clr),
        .ld_val (hi_val),
        .q      (hi_q)
    );

    dpx_rd_mux #(.N_PAGE(N_PAGE), .PAGE_W(PAGE_W)) u_rd (
        .lo_q    (lo_q),
        .hi_q    (hi_q),
        .rd_hi   (rd_hi),
        .rd_word (rd_word),
        .rd_ofs  (rd_ofs),
        .rd_data (rd_data)
    );

    dpx_addr_form #(
        .N_PAGE(N_PAGE), .PAGE_W(PAGE_W), .CUR_W(CUR_W), .WORD_CTRL(WORD_CTRL)
    ) u_addr (
        .lo_q      (lo_q),
        .hi_q      (hi_q),
        .ch_idx    (ch_idx),
        .cur_addr  (cur_addr),
        .phys_addr (phys_addr)
    );
endmodule

// File: rtl/dpx_chk.sv
// Property checker for dma_page_extender, attached through bind.
// Observes the write port, the bank contents and the formed address.
module dpx_chk #(
    parameter int N_PAGE    = 8,
    parameter int PAGE_W    = 8,
    parameter int CUR_W     = 16,
    parameter bit WORD_CTRL = 1'b0,
    localparam int OFS_W    = $clog2(N_PAGE),
    localparam int PHYS_W   = 2*PAGE_W + CUR_W
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic                          wr_hi,
    input logic                          wr_word,
    input logic [OFS_W-1:0]              wr_ofs,
    input logic [2*PAGE_W-1:0]           wr_data,
    input logic [CUR_W-1:0]              cur_addr,
    input logic [PHYS_W-1:0]             phys_addr,
    input logic [N_PAGE-1:0][PAGE_W-1:0] lo_q,
    input logic [N_PAGE-1:0][PAGE_W-1:0] hi_q
);
    // R9: the cycle after reset, both banks are empty.
    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (lo_q == '0 && hi_q == '0));

    // R2: a low byte write clears the matching high page.
    a_r2_lo_byte_clears_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hi && !wr_word)
        |=> (hi_q[$past(wr_ofs)] == '0 && lo_q[$past(wr_ofs)] == $past(wr_data[PAGE_W-1:0])));

    // R3: a low word write loads both bytes, wrapping the second offset.
    a_r3_word_two_regs: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hi && wr_word)
        |=> (lo_q[$past(wr_ofs)] == $past(wr_data[PAGE_W-1:0])
             && lo_q[$past(wr_ofs) + OFS_W'(1)] == $past(wr_data[2*PAGE_W-1:PAGE_W])
             && hi_q[$past(wr_ofs) + OFS_W'(1)] == '0));

    // R4: a high byte write leaves the low bank alone.
    a_r4_hi_byte_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hi && !wr_word) |=> $stable(lo_q));

    // R5: a high word write changes nothing.
    a_r5_hi_word_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hi && wr_word) |=> ($stable(lo_q) && $stable(hi_q)));

    // R7 / R8: the low address bits follow the current address per variant.
    if (WORD_CTRL) begin : g_w
        a_r8_word_shift: assert property (@(posedge clk) disable iff (!rst_n)
            (phys_addr[0] == 1'b0 && phys_addr[CUR_W:1] == cur_addr));
    end else begin : g_b
        a_r7_byte_pass: assert property (@(posedge clk) disable iff (!rst_n)
            phys_addr[CUR_W-1:0] == cur_addr);
    end
endmodule

bind dma_page_extender dpx_chk #(
    .N_PAGE(N_PAGE), .PAGE_W(PAGE_W), .CUR_W(CUR_W), .WORD_CTRL(WORD_CTRL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_hi     (wr_hi),
    .wr_word   (wr_word),
    .wr_ofs    (wr_ofs),
    .wr_data   (wr_data),
    .cur_addr  (cur_addr),
    .phys_addr (phys_addr),
    .lo_q      (lo_q),
    .hi_q      (hi_q)
);

// File: tb/sim_dma_page_extender.sv
// Bench: the byte variant (u0) and the word variant (u1) share all stimulus.
module sim_dma_page_extender;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_hi = 1'b0, wr_word = 1'b0;
    logic [2:0]  wr_ofs = '0;
    logic [15:0] wr_data = '0;
    logic        rd_hi = 1'b0, rd_word = 1'b0;
    logic [2:0]  rd_ofs = '0;
    logic [1:0]  ch_idx = '0;
    logic [15:0] cur_addr = '0;
    logic [15:0] rd_data0, rd_data1;
    logic [31:0] phys0, phys1;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_page_extender #(.WORD_CTRL(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_word(wr_word),
        .wr_ofs(wr_ofs), .wr_data(wr_data), .rd_hi(rd_hi), .rd_word(rd_word),
        .rd_ofs(rd_ofs), .rd_data(rd_data0), .ch_idx(ch_idx), .cur_addr(cur_addr),
        .phys_addr(phys0));

    dma_page_extender #(.WORD_CTRL(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_word(wr_word),
        .wr_ofs(wr_ofs), .wr_data(wr_data), .rd_hi(rd_hi), .rd_word(rd_word),
        .rd_ofs(rd_ofs), .rd_data(rd_data1), .ch_idx(ch_idx), .cur_addr(cur_addr),
        .phys_addr(phys1));

    // Vector: {is_read, hi, word, ofs[2:0], data[15:0], exp[15:0]}
    typedef logic [37:0] vec_t;
    localparam int NVEC = 19;
    localparam vec_t VECS [NVEC] = '{
        {1'b0,1'b0,1'b0,3'd2,16'h0011,16'h0000}, // lo byte 2 = 11
        {1'b0,1'b1,1'b0,3'd2,16'h00A2,16'h0000}, // hi byte 2 = A2
        {1'b1,1'b1,1'b0,3'd2,16'h0000,16'h00A2}, // R4 hi read
        {1'b1,1'b0,1'b0,3'd2,16'h0000,16'h0011}, // R4 lo untouched
        {1'b0,1'b0,1'b0,3'd2,16'h0033,16'h0000}, // lo byte 2 = 33
        {1'b1,1'b1,1'b0,3'd2,16'h0000,16'h0000}, // R2 hi cleared
        {1'b1,1'b0,1'b0,3'd2,16'h0000,16'h0033}, // R2 lo loaded
        {1'b0,1'b1,1'b0,3'd7,16'h00B7,16'h0000}, // hi 7
        {1'b0,1'b1,1'b0,3'd0,16'h00B0,16'h0000}, // hi 0
        {1'b0,1'b0,1'b1,3'd7,16'h5544,16'h0000}, // word at 7 wraps to 0
        {1'b1,1'b0,1'b1,3'd7,16'h0000,16'h5544}, // R3 word read wraps
        {1'b1,1'b1,1'b0,3'd7,16'h0000,16'h0000}, // R3 hi 7 cleared
        {1'b1,1'b1,1'b0,3'd0,16'h0000,16'h0000}, // R3 hi 0 cleared
        {1'b1,1'b0,1'b0,3'd0,16'h0000,16'h0055}, // R3 lo 0 high byte
        {1'b0,1'b1,1'b0,3'd3,16'h00C3,16'h0000}, // hi 3 = C3
        {1'b0,1'b1,1'b1,3'd3,16'h7766,16'h0000}, // R5 hi word write
        {1'b1,1'b1,1'b0,3'd3,16'h0000,16'h00C3}, // R5 hi 3 kept
        {1'b1,1'b1,1'b1,3'd3,16'h0000,16'h0000}, // R5 hi word read = 0
        {1'b1,1'b0,1'b1,3'd1,16'h0000,16'h3300}  // R6 word read 1
    };

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic hi, input logic word, input logic [2:0] ofs,
                            input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_hi = hi; wr_word = word; wr_ofs = ofs; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic hi, input logic word, input logic [2:0] ofs);
        rd_hi = hi; rd_word = word; rd_ofs = ofs;
        #1;
    endtask

    task automatic chk_addr(input logic [1:0] ch, input logic [15:0] cur,
                            input logic [31:0] e0, input logic [31:0] e1);
        ch_idx = ch; cur_addr = cur;
        #1;
        check32("R1/R7 byte variant", phys0, e0);
        check32("R1/R8 word variant", phys1, e1);
    endtask

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state, every register reads zero.
        for (int i = 0; i < 8; i++) begin
            do_read(1'b0, 1'b1, 3'(i));
            check16("R9 reset lo", rd_data0, 16'h0000);
            do_read(1'b1, 1'b0, 3'(i));
            check16("R9 reset hi", rd_data1, 16'h0000);
        end

        // Table walk: writes and checked reads, on both variants.
        for (int v = 0; v < NVEC; v++) begin
            if (VECS[v][37]) begin
                do_read(VECS[v][36], VECS[v][35], VECS[v][34:32]);
                check16("R6 table u0", rd_data0, VECS[v][15:0]);
                check16("R6 table u1", rd_data1, VECS[v][15:0]);
            end else begin
                do_write(VECS[v][36], VECS[v][35], VECS[v][34:32], VECS[v][31:16]);
            end
        end

        // R9: write latency - old value visible before the edge.
        @(negedge clk);
        wr_en = 1'b1; wr_hi = 1'b0; wr_word = 1'b0; wr_ofs = 3'd5; wr_data = 16'h009C;
        do_read(1'b0, 1'b0, 3'd5);
        check16("R9 before edge", rd_data0, 16'h0000);
        @(negedge clk);
        wr_en = 1'b0;
        do_read(1'b0, 1'b0, 3'd5);
        check16("R9 after edge", rd_data0, 16'h009C);

        // Set the channel page pairs (lo first, since lo writes clear hi).
        do_write(1'b0, 1'b0, 3'd7, 16'h0013); do_write(1'b1, 1'b0, 3'd7, 16'h00C7);
        do_write(1'b0, 1'b0, 3'd3, 16'h0024); do_write(1'b1, 1'b0, 3'd3, 16'h00D3);
        do_write(1'b0, 1'b0, 3'd1, 16'h0035); do_write(1'b1, 1'b0, 3'd1, 16'h00E1);
        do_write(1'b0, 1'b0, 3'd2, 16'h0046); do_write(1'b1, 1'b0, 3'd2, 16'h00F2);

        // R1, R7, R8: channel map and both address forms.
        chk_addr(2'd0, 16'h8001, 32'hC7138001, 32'hC7130002);
        chk_addr(2'd1, 16'h8001, 32'hD3248001, 32'hD3250002);
        chk_addr(2'd2, 16'h8001, 32'hE1358001, 32'hE1350002);
        chk_addr(2'd3, 16'h8001, 32'hF2468001, 32'hF2470002);
        chk_addr(2'd0, 16'h1234, 32'hC7131234, 32'hC7122468);

        // R9: reset clears populated banks.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        do_read(1'b0, 1'b1, 3'd7);
        check16("R9 re-reset lo", rd_data0, 16'h0000);
        do_read(1'b1, 1'b0, 3'd1);
        check16("R9 re-reset hi", rd_data0, 16'h0000);
        chk_addr(2'd1, 16'h0000, 32'h00000000, 32'h00000000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule